// File: doc/BRIEF.md
# Adaptive Interrupt Holdoff Counter

This block decides, cycle by cycle, whether a pipelined core may take an interrupt. The pipeline sometimes starts an interrupt and then has to drop it, because an older instruction still in flight turned interrupts off. When that happens, the pipeline sends a deferral pulse. The block then arms a down-counter, and no request is accepted until the counter drains. This gives the interrupted code a window in which it can make progress, instead of the core refetching the handler again and again.

If the next deferral arrives soon after a window has closed, the core is caught in a flush-and-refetch loop. In that case the next window is twice as long, up to a cap. A retired interrupt-enable instruction returns the window length to its minimum. The minimum can be a fixed default or a value that software programs. The acceptance output is registered.

Top module: `irq_holdoff`

## Requirements
- R1: A synchronous reset forces `accept_q` low and clears the counter. The reload value after reset is the current minimum.
- R2: `accept_q` equals, one clock later, `irq_req & irq_en & (counter == 0)`.
- R3: A deferral loads the counter. With requests pending and enabled throughout, `accept_q` stays low for exactly the loaded number of cycles after the first post-deferral cycle.
- R4: With `prog_min` = 0, the minimum holdoff is 10 cycles.
- R5: A loop deferral doubles the reload value and loads the doubled value. A loop deferral is one that arrives while the counter is zero, after an expiry, within fewer than 2 x reload cycles since that expiry, and with no enable retire since then.
- R6: The reload value saturates at `MAX_HOLD` (default 160). A loop deferral at 160 reloads 160.
- R7: A deferral that arrives while the counter is zero but outside the loop window reloads the minimum.
- R8: A retired enable instruction sets the reload value to the minimum and cancels the loop window. If a deferral arrives in the same cycle, the counter loads the minimum.
- R9: A deferral while the counter is nonzero restarts the counter with the unchanged reload value.
- R10: A nonzero `prog_min` sets the minimum. Values above `MAX_HOLD` are clamped to `MAX_HOLD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | An interrupt request is pending |
| irq_en | input | 1 | Global interrupt enable |
| defer_pulse | input | 1 | A taken interrupt was abandoned by the pipeline |
| ena_retire | input | 1 | An interrupt-enable instruction retired |
| prog_min | input | W ($clog2(MAX_HOLD+1)) | Programmed minimum holdoff; 0 selects the default |
| accept_q | output | 1 | Registered interrupt acceptance |

## Verification
The hardest state to reach is a deferral that lands inside the loop window after several escalations. The stimulus needs chains of deferrals, each placed a few cycles after the previous window has drained. The directed sequences do exactly that, back to back, and measure each window length from `accept_q`: 10, 20, 40, 80, 160, 160. Long idle stretches then take the block past the window limit. Random traffic with rare deferral and enable pulses, compared against a cycle model in the bench, covers the window edges and the coincident pulse cases.

// File: rtl/irq_holdoff_pkg.sv
package irq_holdoff_pkg;
  // choice of the next reload value on a deferral
  typedef enum logic [1:0] {
    RL_KEEP = 2'd0,
    RL_MIN  = 2'd1,
    RL_GROW = 2'd2
  } rl_sel_e;
endpackage

// File: rtl/irq_holdoff_minsel.sv
module irq_holdoff_minsel #(
  parameter int W        = 8,
  parameter int MIN_DEF  = 10,
  parameter int MAX_HOLD = 160,
  parameter bit USE_PROG = 1'b1
) (
  input  logic [W-1:0] prog_min,
  output logic [W-1:0] min_val
);
  localparam logic [W-1:0] MIN_L = W'(MIN_DEF);
  localparam logic [W-1:0] MAX_L = W'(MAX_HOLD);

  generate
    if (USE_PROG) begin : g_prog
      always_comb begin
        if (prog_min == '0)         min_val = MIN_L;
        else if (prog_min > MAX_L)  min_val = MAX_L;
        else                        min_val = prog_min;
      end
    end else begin : g_fixed
      // programmed value only matters when the option is built in
      always_comb min_val = (prog_min == prog_min) ? MIN_L : MIN_L;
    end
  endgenerate
endmodule

// File: rtl/irq_holdoff_cnt.sv
module irq_holdoff_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero,
  output logic         expire
);
  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign zero   = (cnt == '0);
  assign expire = (cnt == W'(1)) && !load;
endmodule

// File: rtl/irq_holdoff_reload.sv
module irq_holdoff_reload
  import irq_holdoff_pkg::*;
#(
  parameter int W        = 8,
  parameter int MAX_HOLD = 160
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         defer,
  input  logic         ena,
  input  logic         zero,
  input  logic         expire,
  input  logic [W-1:0] min_val,
  output logic [W-1:0] rel_q,
  output logic [W-1:0] load_val
);
  localparam int GW = W + 1;
  localparam logic [W-1:0]  MAX_L   = W'(MAX_HOLD);
  localparam logic [GW-1:0] MAX_G   = GW'(MAX_HOLD);
  localparam logic [GW-1:0] GAP_CAP = GW'(2 * MAX_HOLD);

  logic          recent_q;
  logic [GW-1:0] gap_q;
  logic [GW-1:0] dbl;
  logic [W-1:0]  grown;
  logic          in_window;
  rl_sel_e       sel;

  assign dbl       = {rel_q, 1'b0};
  assign grown     = (dbl > MAX_G) ? MAX_L : dbl[W-1:0];
  assign in_window = recent_q && zero && (gap_q < dbl);

  always_comb begin
    if (ena)            sel = RL_MIN;
    else if (!zero)     sel = RL_KEEP;
    else if (in_window) sel = RL_GROW;
    else                sel = RL_MIN;
  end

  always_comb begin
    unique case (sel)
      RL_KEEP: load_val = rel_q;
      RL_GROW: load_val = grown;
      default: load_val = min_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q    <= min_val;
      recent_q <= 1'b0;
      gap_q    <= '0;
    end else begin
      if (defer)    rel_q <= load_val;
      else if (ena) rel_q <= min_val;

      if (ena || defer)   recent_q <= 1'b0;
      else if (expire)    recent_q <= 1'b1;

      if (expire)                                   gap_q <= '0;
      else if (recent_q && zero && gap_q != GAP_CAP) gap_q <= gap_q + GW'(1);
    end
  end
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int MAX_HOLD = 160,
  parameter int MIN_DEF  = 10,
  parameter bit USE_PROG = 1'b1,
  parameter int W        = $clog2(MAX_HOLD + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         irq_req,
  input  logic         irq_en,
  input  logic         defer_pulse,
  input  logic         ena_retire,
  input  logic [W-1:0] prog_min,
  output logic         accept_q
);
  logic [W-1:0] min_val;
  logic [W-1:0] reload_q;
  logic [W-1:0] load_val;
  logic [W-1:0] hold_cnt;
  logic         cnt_zero;
  logic         cnt_expire;

  irq_holdoff_minsel #(
    .W(W), .MIN_DEF(MIN_DEF), .MAX_HOLD(MAX_HOLD), .USE_PROG(USE_PROG)
  ) u_minsel (
    .prog_min (prog_min),
    .min_val  (min_val)
  );

  irq_holdoff_reload #(.W(W), .MAX_HOLD(MAX_HOLD)) u_reload (
    .clk      (clk),
    .rst      (rst),
    .defer    (defer_pulse),
    .ena      (ena_retire),
    .zero     (cnt_zero),
    .expire   (cnt_expire),
    .min_val  (min_val),
    .rel_q    (reload_q),
    .load_val (load_val)
  );

  irq_holdoff_cnt #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (defer_pulse),
    .load_val (load_val),
    .cnt      (hold_cnt),
    .zero     (cnt_zero),
    .expire   (cnt_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) accept_q <= 1'b0;
    else     accept_q <= irq_req && irq_en && cnt_zero;
  end
endmodule

// File: rtl/irq_holdoff_chk.sv
module irq_holdoff_chk #(
  parameter int MAX_HOLD = 160,
  parameter int W        = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         irq_req,
  input logic         irq_en,
  input logic         defer_pulse,
  input logic         ena_retire,
  input logic         accept_q,
  input logic [W-1:0] hold_cnt,
  input logic [W-1:0] reload_q,
  input logic [W-1:0] min_val
);
  localparam logic [W-1:0] MAX_L = W'(MAX_HOLD);

  // R2: an active holdoff blocks acceptance in the next cycle
  a_r2_blocked_when_counting: assert property (@(posedge clk) disable iff (rst)
    (hold_cnt != '0) |=> !accept_q);

  // R2: acceptance needs a pending, enabled request one cycle earlier
  a_r2_needs_request: assert property (@(posedge clk) disable iff (rst)
    accept_q |-> $past(irq_req && irq_en));

  // R3: a deferral always arms the counter
  a_r3_defer_arms: assert property (@(posedge clk) disable iff (rst)
    defer_pulse |=> (hold_cnt != '0));

  // R3: without a deferral the counter drains by one per cycle
  a_r3_drains: assert property (@(posedge clk) disable iff (rst)
    (hold_cnt != '0 && !defer_pulse) |=> (hold_cnt == $past(hold_cnt) - W'(1)));

  // R5: a deferral in the idle state either resets, doubles or saturates
  a_r5_growth_shape: assert property (@(posedge clk) disable iff (rst)
    (defer_pulse && hold_cnt == '0) |=>
      (reload_q == $past(min_val)) || (reload_q == MAX_L) ||
      ({1'b0, reload_q} == {$past(reload_q), 1'b0}));

  // R6: the reload value stays within its range
  a_r6_reload_cap: assert property (@(posedge clk) disable iff (rst)
    (reload_q <= MAX_L) && (reload_q != '0));

  // R8: an enable retire restores the minimum
  a_r8_enable_min: assert property (@(posedge clk) disable iff (rst)
    ena_retire |=> (reload_q == $past(min_val)));
endmodule

bind irq_holdoff irq_holdoff_chk #(.MAX_HOLD(MAX_HOLD), .W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_req     (irq_req),
  .irq_en      (irq_en),
  .defer_pulse (defer_pulse),
  .ena_retire  (ena_retire),
  .accept_q    (accept_q),
  .hold_cnt    (hold_cnt),
  .reload_q    (reload_q),
  .min_val     (min_val)
);

// File: tb/sim_irq_holdoff.sv
`timescale 1ns/1ps
module sim_irq_holdoff;
  localparam int MAXH = 160;
  localparam int MIND = 10;
  localparam int W    = $clog2(MAXH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_req = 1'b0, irq_en = 1'b0, defer_pulse = 1'b0, ena_retire = 1'b0;
  logic [W-1:0] prog_min = '0;
  logic accept_q;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic seen;

  // bench cycle model
  int  m_cnt, m_rel, m_gap;
  bit  m_recent;
  logic m_acc;

  always #10 clk = ~clk;

  irq_holdoff #(.MAX_HOLD(MAXH), .MIN_DEF(MIND), .USE_PROG(1'b1)) u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en),
    .defer_pulse(defer_pulse), .ena_retire(ena_retire),
    .prog_min(prog_min), .accept_q(accept_q)
  );

  function automatic int min_of(input int pm);
    if (pm == 0)    return MIND;
    if (pm > MAXH)  return MAXH;
    return pm;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s accept_q actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_len(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s holdoff length actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: sample previous result, drive inputs, advance model
  task automatic step(input logic rq, input logic en, input logic df,
                      input logic er, input int pm, input string tag);
    int mn, ld, nrel;
    bit expire, inwin;
    @(negedge clk);
    seen = accept_q;
    check_bit(tag, seen, m_acc);
    irq_req = rq; irq_en = en; defer_pulse = df; ena_retire = er;
    prog_min = W'(pm);
    mn     = min_of(pm);
    m_acc  = rq & en & (m_cnt == 0);
    expire = (m_cnt == 1) && !df;
    inwin  = m_recent && (m_cnt == 0) && (m_gap < 2 * m_rel);
    if (er)              ld = mn;
    else if (m_cnt != 0) ld = m_rel;
    else if (inwin)      ld = (2 * m_rel > MAXH) ? MAXH : 2 * m_rel;
    else                 ld = mn;
    nrel = df ? ld : (er ? mn : m_rel);
    if (expire) m_gap = 0;
    else if (m_recent && m_cnt == 0 && m_gap != 2 * MAXH) m_gap++;
    if (er || df) m_recent = 1'b0;
    else if (expire) m_recent = 1'b1;
    if (df) m_cnt = ld;
    else if (m_cnt != 0) m_cnt--;
    m_rel = nrel;
  endtask

  task automatic hold_len(input logic er, input int pm, input string tag, output int n);
    step(1'b1, 1'b1, 1'b1, er, pm, tag);
    step(1'b1, 1'b1, 1'b0, 1'b0, pm, tag);
    n = 0;
    do begin
      step(1'b1, 1'b1, 1'b0, 1'b0, pm, tag);
      if (!seen) n++;
    end while (!seen && n < 400);
  endtask

  task automatic idle(input int k, input int pm);
    for (int i = 0; i < k; i++) step(1'b1, 1'b1, 1'b0, 1'b0, pm, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1a2b));
    repeat (3) @(negedge clk);
    check_bit("R1", accept_q, 1'b0);
    rst = 1'b0;
    m_cnt = 0; m_rel = MIND; m_gap = 0; m_recent = 1'b0; m_acc = 1'b0;

    // R2 input combinations
    step(1, 0, 0, 0, 0, "R2"); step(0, 1, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 0, "R2"); step(0, 0, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 0, "R2"); step(1, 1, 0, 0, 0, "R2");

    // R4 first window after reset, then R5 loop escalation, R6 cap
    hold_len(0, 0, "R4", n); check_len("R4", n, 10);
    hold_len(0, 0, "R5", n); check_len("R5", n, 20);
    hold_len(0, 0, "R5", n); check_len("R5", n, 40);
    hold_len(0, 0, "R5", n); check_len("R5", n, 80);
    hold_len(0, 0, "R5", n); check_len("R5", n, 160);
    hold_len(0, 0, "R6", n); check_len("R6", n, 160);

    // R7 late deferral falls back to the minimum
    idle(400, 0);
    hold_len(0, 0, "R7", n); check_len("R7", n, 10);
    hold_len(0, 0, "R5", n); check_len("R5", n, 20);

    // R8 coincident deferral and enable retire
    hold_len(1, 0, "R8", n); check_len("R8", n, 10);
    hold_len(0, 0, "R5", n); check_len("R5", n, 20);
    step(1, 1, 0, 1, 0, "R8"); idle(2, 0);
    hold_len(0, 0, "R8", n); check_len("R8", n, 10);

    // R9 deferral during an active window restarts it
    idle(400, 0);
    step(1, 1, 1, 0, 0, "R9");
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, "R9");
    step(1, 1, 1, 0, 0, "R9");
    for (int i = 0; i < 14; i++) step(1, 1, 0, 0, 0, "R9");

    // R10 programmed minimum and clamping
    idle(400, 5);
    hold_len(0, 5, "R10", n); check_len("R10", n, 5);
    idle(400, 200);
    hold_len(0, 200, "R10", n); check_len("R10", n, 160);
    idle(400, 0);
    hold_len(0, 0, "R10", n); check_len("R10", n, 10);

    // random traffic against the model
    begin
      int pm = 0;
      for (int i = 0; i < 20000; i++) begin
        if ($urandom_range(499) == 0) begin
          case ($urandom_range(5))
            0: pm = 0; 1: pm = 3; 2: pm = 5; 3: pm = 30; 4: pm = 200; default: pm = 10;
          endcase
        end
        step($urandom_range(3) != 0, $urandom_range(3) != 0,
             $urandom_range(29) == 0, $urandom_range(99) == 0, pm, "R2");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule